// File: doc/BRIEF.md
# Stepped Experiment Clock Controller

This block runs a device under test from a free-running system clock. The device's clock is not free-running. It advances only when software asks for a single step, or while the controller is in autonomous run mode. The clock is modelled as a one-cycle enable, `xclk_en`, that gates the device's flops. The block also drives a synchronous reset for the device, `xrst`, separately from any data path.

Commands arrive as a two-bit code on a valid/ready handshake. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls while a reset or a step is in progress. A source that holds `cmd_valid` across that time keeps its command until the controller is ready again, so back-pressure only delays a command and never drops it.

The block reports on these pins:
- `done` pulses once when an accepted command has been carried out.
- `err` pulses when a command is refused.
- `running` shows autonomous mode.
- `cycle_count` counts every gated pulse.

Top module: `stepclk_ctrl`

## Requirements
- R1: A command is accepted only on a clock edge where `cmd_valid` and `cmd_ready` are both high. Codes are 2'b00 reset, 2'b01 step, 2'b10 start and 2'b11 pause. `cmd_ready` is low while a reset or step is in progress, and a valid command in that time has no effect.
- R2: A reset accepted while idle clears `cycle_count` to 0 at the accepting edge. It then holds `xrst` high for exactly `RST_CYCLES` cycles with `xclk_en` low, returns to idle and pulses `done` in the first cycle after `xrst` falls.
- R3: A step accepted while idle raises `xclk_en` for exactly one cycle, starting in the cycle after acceptance. `done` pulses in the cycle after that enable, when `cycle_count` has grown by one.
- R4: A start accepted while idle raises `running` and `xclk_en` from the next cycle onward, continuously. `done` pulses in that same first cycle.
- R5: A pause accepted while running drops `running` and `xclk_en` from the next cycle and pulses `done` in that cycle. The accepting edge still counts one enable cycle.
- R6: A pause accepted while idle pulses `done` in the next cycle and changes nothing else.
- R7: A step or reset accepted while running is refused. `err` pulses in the next cycle, no `done` follows, and running mode and counting go on.
- R8: A start accepted while running pulses `done` in the next cycle and leaves running mode unchanged.
- R9: `cycle_count` increases by exactly one at every clock edge where `xclk_en` is high, and at no other edge except the reset clear.
- R10: Each accepted command gives exactly one `done` or one `err` pulse, and the two are never high together.
- R11: While global reset `rst` is high and after it, the controller is idle: `cmd_ready` is 1, and `xclk_en`, `xrst`, `running`, `done`, `err` and `cycle_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous global reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_code | input | 2 | Command code (see R1) |
| xclk_en | output | 1 | Experiment clock enable, one per device cycle |
| xrst | output | 1 | Synchronous reset for the device under test |
| running | output | 1 | Autonomous run mode active |
| cycle_count | output | CNT_W | Number of experiment clock pulses since the last reset |
| done | output | 1 | One-cycle acknowledge of a completed command |
| err | output | 1 | One-cycle pulse for a refused command |

## Verification
The assertions assume that the global reset is held for at least one edge. They take any pattern of `cmd_valid` and `cmd_code` as legal, because the handshake itself filters busy periods. The stimulus mostly waits for `cmd_ready` before offering a command. On purpose, it also offers a step while a reset is in progress, which must be refused by back-pressure. Running-mode counts are checked only against a known number of edges between start and pause, so no check depends on free-running timing.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESET = 2'd1,
    ST_STEP  = 2'd2,
    ST_RUN   = 2'd3
  } stepclk_state_t;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_STEP  = 2'b01,
    OP_START = 2'b10,
    OP_PAUSE = 2'b11
  } stepclk_op_t;
endpackage

// File: rtl/stepclk_rst_timer.sv
module stepclk_rst_timer #(
  parameter int CYCLES = 2,
  parameter int W      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic last
);
  logic [W-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst || clr) tick <= '0;
    else if (en)    tick <= tick + 1'b1;
  end

  assign last = (tick == W'(CYCLES - 1));
endmodule

// File: rtl/stepclk_cycle_ctr.sv
module stepclk_cycle_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/stepclk_fsm.sv
module stepclk_fsm
  import stepclk_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_code,
  input  logic           tmr_last,
  output stepclk_state_t state,
  output logic           cmd_ready,
  output logic           tmr_clr,
  output logic           tmr_en,
  output logic           ctr_clr,
  output logic           done,
  output logic           err
);
  logic        take;
  stepclk_op_t op;

  always_comb begin
    op        = stepclk_op_t'(cmd_code);
    cmd_ready = (state == ST_IDLE) || (state == ST_RUN);
    take      = cmd_valid && cmd_ready;
    tmr_clr   = take && (state == ST_IDLE) && (op == OP_RESET);
    ctr_clr   = tmr_clr;
    tmr_en    = (state == ST_RESET);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          case (op)
            OP_RESET: state <= ST_RESET;
            OP_STEP:  state <= ST_STEP;
            OP_START: begin state <= ST_RUN; done <= 1'b1; end
            default:  done <= 1'b1;
          endcase
        end
        ST_RESET: if (tmr_last) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        ST_STEP: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: if (take) begin
          case (op)
            OP_PAUSE: begin state <= ST_IDLE; done <= 1'b1; end
            OP_START: done <= 1'b1;
            default:  err  <= 1'b1;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/stepclk_ctrl.sv
module stepclk_ctrl
  import stepclk_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_code,
  output logic             xclk_en,
  output logic             xrst,
  output logic             running,
  output logic [CNT_W-1:0] cycle_count,
  output logic             done,
  output logic             err
);
  localparam int TMR_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

  stepclk_state_t state;
  logic tmr_clr, tmr_en, tmr_last, ctr_clr;

  stepclk_fsm u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .tmr_last(tmr_last), .state(state), .cmd_ready(cmd_ready),
    .tmr_clr(tmr_clr), .tmr_en(tmr_en), .ctr_clr(ctr_clr),
    .done(done), .err(err)
  );

  stepclk_rst_timer #(.CYCLES(RST_CYCLES), .W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en), .last(tmr_last)
  );

  assign xclk_en = (state == ST_STEP) || (state == ST_RUN);
  assign xrst    = (state == ST_RESET);
  assign running = (state == ST_RUN);

  stepclk_cycle_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(xclk_en), .count(cycle_count)
  );
endmodule

// File: rtl/stepclk_ctrl_chk.sv
module stepclk_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_code,
  input logic             xclk_en,
  input logic             xrst,
  input logic             running,
  input logic [CNT_W-1:0] cycle_count,
  input logic             done,
  input logic             err
);
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (xrst || (xclk_en && !running)) |-> !cmd_ready);

  a_r2_no_clock_in_reset: assert property (@(posedge clk) disable iff (rst)
    xrst |-> (!xclk_en && !running));

  a_r2_reset_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(xrst) |-> (done && cycle_count == '0));

  a_r3_step_single: assert property (@(posedge clk) disable iff (rst)
    (xclk_en && !running) |=> !xclk_en);

  a_r4_run_enable: assert property (@(posedge clk) disable iff (rst)
    running |-> xclk_en);

  a_r4_start_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> done);

  a_r7_err_while_running: assert property (@(posedge clk) disable iff (rst)
    err |-> running);

  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    xclk_en |=> (cycle_count - $past(cycle_count) == CNT_W'(1)));

  a_r10_done_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
endmodule

bind stepclk_ctrl stepclk_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_stepclk_ctrl.sv
module sim_stepclk_ctrl;
  localparam int CNT_W = 32;
  localparam int RSTC  = 2;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic cmd_ready, xclk_en, xrst, running, done, err;
  logic [CNT_W-1:0] cycle_count;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  stepclk_ctrl #(.CNT_W(CNT_W), .RST_CYCLES(RSTC)) u0 (.*);

  // row: [12:11] code, [10] expect err, [9] expect running, [8] check count, [7:0] count
  localparam logic [12:0] VEC [11] = '{
    {2'b00, 1'b0, 1'b0, 1'b1, 8'd0},
    {2'b01, 1'b0, 1'b0, 1'b1, 8'd1},
    {2'b01, 1'b0, 1'b0, 1'b1, 8'd2},
    {2'b11, 1'b0, 1'b0, 1'b1, 8'd2},
    {2'b10, 1'b0, 1'b1, 1'b0, 8'd0},
    {2'b01, 1'b1, 1'b1, 1'b0, 8'd0},
    {2'b00, 1'b1, 1'b1, 1'b0, 8'd0},
    {2'b10, 1'b0, 1'b1, 1'b0, 8'd0},
    {2'b11, 1'b0, 1'b0, 1'b0, 8'd0},
    {2'b00, 1'b0, 1'b0, 1'b1, 8'd0},
    {2'b01, 1'b0, 1'b0, 1'b1, 8'd1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, output logic gd, output logic ge,
                      output int nx, output int ne);
    nx = 0; ne = 0; gd = 0; ge = 0;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (xrst) nx++;
      if (xclk_en) ne++;
      if (done || err) begin gd = done; ge = err; break; end
      @(negedge clk);
    end
  endtask

  function automatic string tag(input logic [1:0] c, input logic e, input logic prun);
    if (e) return "R7";
    case (c)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return prun ? "R8" : "R4";
      default: return prun ? "R5" : "R6";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic gd, ge, prun;
    int nx, ne;
    logic [CNT_W-1:0] c0;
    repeat (3) @(negedge clk);
    check("R11 ready", cmd_ready, 1);
    check("R11 outputs", {xclk_en, xrst, running, done, err}, 0);
    check("R11 count", cycle_count, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 idle after reset", {xclk_en, xrst, running, done, err}, 0);

    for (int i = 0; i < 11; i++) begin
      prun = running;
      send(VEC[i][12:11], gd, ge, nx, ne);
      check({tag(VEC[i][12:11], VEC[i][10], prun), " done"}, gd, !VEC[i][10]);
      check({tag(VEC[i][12:11], VEC[i][10], prun), " err"}, ge, VEC[i][10]);
      check({tag(VEC[i][12:11], VEC[i][10], prun), " running"}, running, VEC[i][9]);
      if (VEC[i][8])
        check({tag(VEC[i][12:11], VEC[i][10], prun), " count"}, cycle_count, 64'(VEC[i][7:0]));
      if (VEC[i][12:11] == 2'b00 && !VEC[i][10])
        check("R2 reset length", nx, RSTC);
      if (VEC[i][12:11] == 2'b01 && !VEC[i][10])
        check("R3 one pulse", ne, 1);
    end

    // R5 and R9: count over a known run window
    c0 = cycle_count;
    send(2'b10, gd, ge, nx, ne);
    check("R4 start ack", gd, 1);
    repeat (3) @(negedge clk);
    send(2'b11, gd, ge, nx, ne);
    check("R5 pause ack", gd, 1);
    check("R9 run window count", cycle_count, 64'(c0 + 4));
    @(negedge clk);
    check("R5 stopped", {xclk_en, running}, 0);
    check("R10 single done", done, 0);

    // R1 and R3: busy during step, one enable
    cmd_valid = 1'b1; cmd_code = 2'b01;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 not ready in step", cmd_ready, 0);
    check("R3 enable in step", xclk_en, 1);
    @(negedge clk);
    check("R3 done after pulse", {done, xclk_en}, 2'b10);

    // R1: command offered during reset is held off
    cmd_valid = 1'b1; cmd_code = 2'b00;
    @(negedge clk);
    cmd_code = 2'b01;
    check("R1 not ready in reset", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    ne = 0;
    for (int i = 0; i < 6; i++) begin
      if (xclk_en) ne++;
      @(negedge clk);
    end
    check("R1 busy command ignored", ne, 0);
    check("R2 count cleared", cycle_count, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule